// File: doc/BRIEF.md
# Serial-loaded mapper register file

This block sits on the CPU write path of a cartridge controller. Any write in the upper half of the address space carries one data bit toward a 5-bit value. The value is gathered in a right-shifting register that holds a single marker bit. When the fifth bit arrives, the assembled value is stored in one of four configuration registers: control, character bank 0, character bank 1 or program bank. Only the address of that fifth write chooses the register. A write with data bit 7 set abandons a partial load and forces the program-mode bits of the control register high.

Writes in the 0x6000–0x7FFF window do not reach the shift logic. They are only decoded into a write enable for an external work RAM. Writes below 0x6000 have no effect at all. Whenever a serial load completes, the block gives a one-cycle commit pulse together with the index of the register that was written, so that downstream translation logic knows when to refresh.

The block is built from four parts:
- A combinational region decoder, which sorts each write into one of three regions: none, work RAM or port.
- A marker shift accumulator. It is either empty (the marker in bit 4) or partly filled (the marker further right). It reaches the commit transition when the marker sits in bit 0 as a port write arrives. It takes the abort transition on a port write with data bit 7 set.
- A register bank with its commit pulse.
- The top module, which connects them.

Top module: `serial_bank_regs`

## Requirements
- R1: After reset, ctrl_reg is 5'b01100, and chr0_reg, chr1_reg and prg_reg are 0. commit_pulse is 0, and the accumulator is empty, so five port writes are needed for the first commit.
- R2: A port write has wr_en high, addr[15] = 1 and wdata[7] = 0. Each such write shifts the accumulator right by one and enters wdata[0] at bit 4. On the fifth such write, the committed value has the first write's wdata[0] in bit 0 and the fifth write's wdata[0] in bit 4.
- R3: The destination is addr[14:13] of the fifth write alone: 0 = ctrl_reg, 1 = chr0_reg, 2 = chr1_reg, 3 = prg_reg. The addresses of the earlier four writes do not matter, and the other three registers keep their values.
- R4: After a commit the accumulator is empty again, and the next commit needs five more port writes.
- R5: A write with wr_en high, addr[15] = 1 and wdata[7] = 1 empties the accumulator and sets ctrl_reg bits 3 and 2, keeping its other bits. It leaves chr0_reg, chr1_reg and prg_reg unchanged and gives no commit pulse.
- R6: commit_pulse is high for exactly the one cycle that follows the clock edge of a committing write, with commit_idx equal to that write's addr[14:13].
- R7: wram_we equals wr_en in the same cycle whenever addr[15:13] = 3'b011. Such writes leave the accumulator and all registers unchanged.
- R8: A write with addr below 0x6000 leaves wram_we low, the accumulator and all registers unchanged, and gives no commit pulse.
- R9: While wr_en is low, nothing changes, whatever addr and wdata hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr | input | 16 | CPU write address |
| wdata | input | 8 | CPU write data |
| wram_we | output | 1 | Work-RAM write enable (combinational) |
| ctrl_reg | output | 5 | Control register |
| chr0_reg | output | 5 | Character bank 0 register |
| chr1_reg | output | 5 | Character bank 1 register |
| prg_reg | output | 5 | Program bank register |
| commit_pulse | output | 1 | One-cycle pulse after a completed load |
| commit_idx | output | 2 | Index of the register written by the last commit |

## Verification
wram_we is combinational, so the bench checks it in the same cycle as the strobe, one time unit after driving the inputs on the falling edge. The four registers, commit_pulse and commit_idx all change on the rising edge that samples the write, so they are compared on the falling edge that follows. The bench then drops the strobe, so every write is followed by an idle cycle. A reference model in the bench is updated once per write, in the same order as the requirements. It covers the marker accumulator, the abort forcing and the address decoding, so each sample is compared with the state the model holds after that single write.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    parameter int VAL_W  = 5;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    typedef logic [VAL_W-1:0] val_t;

    localparam val_t SHIFT_EMPTY  = val_t'(1) << (VAL_W - 1);
    localparam val_t CTRL_FORCE   = val_t'(5'b01100);
    localparam val_t CTRL_DEFAULT = CTRL_FORCE;
    localparam int   ABORT_BIT    = DATA_W - 1;

    typedef enum logic [1:0] {
        DST_CTRL = 2'd0,
        DST_CHR0 = 2'd1,
        DST_CHR1 = 2'd2,
        DST_PRG  = 2'd3
    } dest_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_WRAM = 2'd1,
        RGN_PORT = 2'd2
    } region_e;
endpackage

// File: rtl/sbr_region_decode.sv
module sbr_region_decode
    import sbr_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              port_we,
    output logic              abort,
    output logic              wram_we,
    output dest_e             dest
);
    region_e region;

    always_comb begin
        unique casez (addr[ADDR_W-1 -: 3])
            3'b1??:  region = RGN_PORT;
            3'b011:  region = RGN_WRAM;
            default: region = RGN_NONE;
        endcase
    end

    always_comb begin
        port_we = wr_en && (region == RGN_PORT);
        wram_we = wr_en && (region == RGN_WRAM);
        abort   = wdata[ABORT_BIT];
        dest    = dest_e'(addr[ADDR_W-2 -: 2]);
    end
endmodule

// File: rtl/sbr_shift_acc.sv
module sbr_shift_acc
    import sbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_en,
    input  logic abort,
    input  logic din,
    output logic commit,
    output val_t value
);
    val_t sreg;

    always_comb begin
        value  = {din, sreg[VAL_W-1:1]};
        commit = acc_en && !abort && sreg[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= SHIFT_EMPTY;
        end else if (acc_en) begin
            if (abort || sreg[0]) sreg <= SHIFT_EMPTY;
            else                  sreg <= value;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(sreg)); // R8
    AST_MARKER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> $countones(sreg) >= 1); // R4
    AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (sreg == SHIFT_EMPTY)); // R4
endmodule

// File: rtl/sbr_reg_bank.sv
module sbr_reg_bank
    import sbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic       abort_en,
    input  dest_e      dest,
    input  val_t       value,
    output val_t       ctrl_q,
    output val_t       chr0_q,
    output val_t       chr1_q,
    output val_t       prg_q,
    output logic       pulse_q,
    output logic [1:0] idx_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_DEFAULT;
            chr0_q  <= '0;
            chr1_q  <= '0;
            prg_q   <= '0;
            pulse_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            pulse_q <= commit;
            if (commit) begin
                idx_q <= dest;
                unique case (dest)
                    DST_CTRL: ctrl_q <= value;
                    DST_CHR0: chr0_q <= value;
                    DST_CHR1: chr1_q <= value;
                    DST_PRG:  prg_q  <= value;
                endcase
            end else if (abort_en) begin
                ctrl_q <= ctrl_q | CTRL_FORCE;
            end
        end
    end

    AST_ABORT_FORCES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_en |=> ((ctrl_q & CTRL_FORCE) == CTRL_FORCE)); // R5
    AST_CHR0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && dest == DST_CHR0) |=> $stable(chr0_q)); // R3
    AST_PRG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && dest == DST_PRG) |=> $stable(prg_q)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R6
endmodule

// File: rtl/serial_bank_regs.sv
module serial_bank_regs
    import sbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic        wram_we,
    output logic [4:0]  ctrl_reg,
    output logic [4:0]  chr0_reg,
    output logic [4:0]  chr1_reg,
    output logic [4:0]  prg_reg,
    output logic        commit_pulse,
    output logic [1:0]  commit_idx
);
    logic  port_we;
    logic  abort;
    logic  commit;
    dest_e dest;
    val_t  value;

    sbr_region_decode u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .port_we (port_we),
        .abort   (abort),
        .wram_we (wram_we),
        .dest    (dest)
    );

    sbr_shift_acc u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_en (port_we),
        .abort  (abort),
        .din    (wdata[0]),
        .commit (commit),
        .value  (value)
    );

    sbr_reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .abort_en (port_we && abort),
        .dest     (dest),
        .value    (value),
        .ctrl_q   (ctrl_reg),
        .chr0_q   (chr0_reg),
        .chr1_q   (chr1_reg),
        .prg_q    (prg_reg),
        .pulse_q  (commit_pulse),
        .idx_q    (commit_idx)
    );

    AST_WRAM_REGION_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wram_we |-> (wr_en && addr[15:13] == 3'b011)); // R7
    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !commit_pulse); // R9
    AST_LOW_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr < 16'h6000) |=> ($stable(ctrl_reg) && !commit_pulse)); // R8
endmodule

// File: tb/test_serial_bank_regs.sv
module test_serial_bank_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wram_we;
    logic [4:0]  ctrl_reg, chr0_reg, chr1_reg, prg_reg;
    logic        commit_pulse;
    logic [1:0]  commit_idx;

    int checks = 0;
    int errors = 0;

    logic [4:0] m_sh, m_ctrl, m_c0, m_c1, m_prg;
    logic       m_pulse;
    logic [1:0] m_idx;

    always #5 clk = ~clk;

    serial_bank_regs i_serial_bank_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wram_we(wram_we), .ctrl_reg(ctrl_reg), .chr0_reg(chr0_reg),
        .chr1_reg(chr1_reg), .prg_reg(prg_reg),
        .commit_pulse(commit_pulse), .commit_idx(commit_idx)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit in_wram(input logic [15:0] a);
        return a[15:13] == 3'b011;
    endfunction

    task automatic model_write(input bit en, input logic [15:0] a, input logic [7:0] d);
        bit done;
        m_pulse = 1'b0;
        if (en && a[15]) begin
            if (d[7]) begin
                m_sh   = 5'b10000;
                m_ctrl = m_ctrl | 5'b01100;
            end else begin
                done = m_sh[0];
                m_sh = {d[0], m_sh[4:1]};
                if (done) begin
                    case (a[14:13])
                        2'd0: m_ctrl = m_sh;
                        2'd1: m_c0   = m_sh;
                        2'd2: m_c1   = m_sh;
                        default: m_prg = m_sh;
                    endcase
                    m_pulse = 1'b1;
                    m_idx   = a[14:13];
                    m_sh    = 5'b10000;
                end
            end
        end
    endtask

    task automatic check_regs();
        chk("R2 R3 R5 ctrl_reg", 8'(ctrl_reg), 8'(m_ctrl));
        chk("R2 R3 chr0_reg", 8'(chr0_reg), 8'(m_c0));
        chk("R2 R3 chr1_reg", 8'(chr1_reg), 8'(m_c1));
        chk("R2 R3 R4 prg_reg", 8'(prg_reg), 8'(m_prg));
        chk("R6 R8 R9 commit_pulse", 8'(commit_pulse), 8'(m_pulse));
        if (m_pulse) chk("R6 commit_idx", 8'(commit_idx), 8'(m_idx));
    endtask

    task automatic do_write(input bit en, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = en; addr = a; wdata = d;
        #1;
        chk("R7 R8 R9 wram_we", 8'(wram_we), 8'(en && in_wram(a)));
        model_write(en, a, d);
        @(negedge clk);
        check_regs();
        wr_en = 1'b0;
    endtask

    task automatic load5(input logic [4:0] v, input logic [15:0] a_last);
        for (int i = 0; i < 4; i++) do_write(1'b1, 16'h8000, {7'b0, v[i]});
        do_write(1'b1, a_last, {7'b0, v[4]});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_sh = 5'b10000; m_ctrl = 5'b01100; m_c0 = '0; m_c1 = '0; m_prg = '0;
        m_pulse = 1'b0; m_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check_regs();
        chk("R1 ctrl default", 8'(ctrl_reg), 8'h0C);

        // R2 R3 each destination, bit order
        load5(5'b10110, 16'h8000);
        load5(5'b00011, 16'hA000);
        load5(5'b11001, 16'hC000);
        load5(5'b01111, 16'hE000);
        // R3 only the last address selects
        do_write(1'b1, 16'hE000, 8'h01);
        do_write(1'b1, 16'hC000, 8'h00);
        do_write(1'b1, 16'hA000, 8'h01);
        do_write(1'b1, 16'hE000, 8'h00);
        do_write(1'b1, 16'h8000, 8'h01);
        // R5 abort mid-load, then a fresh load of five (R4)
        do_write(1'b1, 16'hA000, 8'h01);
        do_write(1'b1, 16'hA000, 8'h01);
        do_write(1'b1, 16'hA000, 8'h80);
        load5(5'b00101, 16'hA000);
        // R7 work RAM and R8 low writes in the middle of a load
        do_write(1'b1, 16'hE000, 8'h01);
        do_write(1'b1, 16'h6000, 8'h01);
        do_write(1'b1, 16'h7FFF, 8'h00);
        do_write(1'b1, 16'h5FFF, 8'h01);
        do_write(1'b1, 16'h0000, 8'h81);
        do_write(1'b0, 16'hE000, 8'h81); // R9
        for (int i = 0; i < 4; i++) do_write(1'b1, 16'hE000, 8'h00);

        // random mix
        for (int i = 0; i < 800; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int r;
            r = $urandom % 8;
            if (r == 0)      a = 16'($urandom % 32'h6000);
            else if (r == 1) a = 16'h6000 + 16'($urandom % 32'h2000);
            else             a = 16'h8000 | 16'($urandom % 32'h8000);
            d = 8'($urandom);
            d[7] = ($urandom % 12) == 0;
            do_write(($urandom % 8) != 0, a, d);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule